// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Register

This block is the receive side of a programmed-I/O serial port. A processor sees two registers, chosen by one select bit. With the select clear, a write loads the control byte and a read returns the status byte. With the select set, a read returns the last received character. The serial input is sampled once per pulse of `os_en`, which the surrounding logic supplies at the chosen oversample rate. The control byte sets the divisor: 1, `DIV_MID` or `DIV_SLOW` enable ticks per bit. It also sets one of eight word formats: 7 or 8 data bits; even, odd or no parity; one or two stop bits.

The receiver is gated by an active-low carrier input. While the carrier is absent, no character is accepted, and a frame in progress is dropped. One character is buffered. Status reports buffer-full, framing, parity and overrun conditions, plus the carrier and clear-to-send inputs as active-low bits. An interrupt line follows the buffer-full flag when the receive interrupt is enabled. Writing a control byte whose divisor field is 3 performs a master reset. The receiver stays held until a byte with another divisor value is written, and that is also the state after reset.

Top module: `serial_rx_port`

## Requirements
- R1: After `rst`, the control byte is 8'h03 and the receiver is held. Status bits, from bit 0 to bit 7, are: buffer full, transmit empty (always 0 here), carrier (`dcd_n`), clear to send (`cts_n`), framing error, overrun, parity error, interrupt. All of them read 0 except bits 2 and 3.
- R2: A read with `sel`=1 returns the buffered byte. The same read clears buffer full, framing error, overrun and parity error.
- R3: Characters arrive with a low start bit, then data bits LSB first, then an optional parity bit, then stop bits. Control bits 4:2 choose the format: 000=7E2, 001=7O2, 010=7E1, 011=7O1, 100=8N2, 101=8N1, 110=8E1, 111=8O1. In 7-bit formats, bit 7 of the stored byte is 0.
- R4: In parity formats, status bit 6 is set when the received parity bit does not give an even total (E) or an odd total (O) over the data and parity bits. In the N formats it is never set.
- R5: Only the first stop bit is sampled. A low level at that sample sets status bit 4.
- R6: If a character completes while buffer full is set, the stored byte and its flags are kept, the new character is dropped, and overrun (status bit 5) is set.
- R7: While `dcd_n` is 1, no character is accepted, and status bit 2 reads 1.
- R8: Control bits 1:0 select ticks per bit: 00=1, 01=`DIV_MID`, 10=`DIV_SLOW`. In the last two modes the start bit is re-checked half a bit after the falling edge. A line that is high again at that point is ignored.
- R9: A control write with bits 1:0 = 11 clears every status bit except bits 2 and 3. The receiver then accepts nothing until a write with another divisor value.
- R10: Control bit 7 enables the receive interrupt. `irq` and status bit 7 are 1 exactly when it is enabled and buffer full is set.
- R11: Status bit 3 reflects `cts_n` directly, 1 meaning inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_en | input | 1 | Oversample tick enable |
| sel | input | 1 | Register select: 0 status/control, 1 data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data (control byte) |
| rd_data | output | 8 | Read data, combinational from `sel` |
| rx_line | input | 1 | Serial input, idle high |
| dcd_n | input | 1 | Carrier detect, active low |
| cts_n | input | 1 | Clear to send, active low |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench uses the default divisors, `DIV_MID`=16 and `DIV_SLOW`=64, and holds `os_en` high. A 64-tick bit then lasts 64 clocks, so several dozen random frames fit in the run while every format, divisor and error injection is covered. Divide-by-1 puts each bit sample on consecutive clocks. That exercises the path that skips the mid-bit start check. The mid-bit re-check is tested with a low pulse shorter than half of a 16-tick bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef struct packed {
        logic       rie;
        logic [2:0] fmt;
        logic [1:0] div;
    } rx_ctrl_t;

    typedef struct packed {
        logic bits8;
        logic has_par;
        logic odd;
    } fmt_info_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    localparam logic [1:0] DIV_RESET = 2'b11;

    function automatic fmt_info_t decode_fmt(input logic [2:0] f);
        fmt_info_t info;
        info.bits8   = f[2];
        info.has_par = !(f == 3'b100 || f == 3'b101);
        info.odd     = f[2] ? (f == 3'b111) : f[0];
        return info;
    endfunction

endpackage

// File: rtl/rx_ctrl_reg.sv
module rx_ctrl_reg
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic [7:0] wr_data,
    output rx_ctrl_t   ctrl,
    output logic       mreset,
    output logic       hold
);
    rx_ctrl_t ctrl_q;

    assign mreset = wr_ctrl && (wr_data[1:0] == DIV_RESET);
    assign hold   = mreset || (ctrl_q.div == DIV_RESET);
    assign ctrl   = ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{rie: 1'b0, fmt: 3'b000, div: DIV_RESET};
        end else if (wr_ctrl) begin
            ctrl_q <= '{rie: wr_data[7], fmt: wr_data[4:2], div: wr_data[1:0]};
        end
    end

endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import serial_rx_pkg::*;
#(
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_en,
    input  logic       rx_line,
    input  logic       dcd_n,
    input  logic       hold,
    input  logic [1:0] div,
    input  fmt_info_t  fmt,
    output logic       done,
    output logic [7:0] out_byte,
    output logic       out_fe,
    output logic       out_pe
);
    localparam int CNT_W = $clog2(DIV_SLOW);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] half;
    logic [2:0]       idx;
    logic [2:0]       last_idx;
    logic [7:0]       data;
    logic             acc;
    logic             perr;
    logic             tick;

    always_comb begin
        case (div)
            2'b01:   begin lim = CNT_W'(DIV_MID - 1);  half = CNT_W'(DIV_MID / 2 - 1);  end
            2'b10:   begin lim = CNT_W'(DIV_SLOW - 1); half = CNT_W'(DIV_SLOW / 2 - 1); end
            default: begin lim = '0;                   half = '0;                       end
        endcase
        last_idx = fmt.bits8 ? 3'd7 : 3'd6;
        tick     = (cnt == lim);
    end

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            data     <= '0;
            acc      <= 1'b0;
            perr     <= 1'b0;
            out_byte <= '0;
            out_fe   <= 1'b0;
            out_pe   <= 1'b0;
        end else if (dcd_n || hold) begin
            state <= ST_IDLE;
        end else if (os_en) begin
            case (state)
                ST_IDLE: if (!rx_line) begin
                    data  <= '0;
                    acc   <= 1'b0;
                    perr  <= 1'b0;
                    idx   <= '0;
                    cnt   <= '0;
                    state <= (div == 2'b00) ? ST_DATA : ST_START;
                end
                ST_START: begin
                    if (cnt == half) begin
                        cnt   <= '0;
                        state <= rx_line ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        cnt       <= '0;
                        data[idx] <= rx_line;
                        acc       <= acc ^ rx_line;
                        idx       <= idx + 3'd1;
                        if (idx == last_idx)
                            state <= fmt.has_par ? ST_PAR : ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (tick) begin
                        cnt   <= '0;
                        perr  <= ((acc ^ rx_line) != fmt.odd);
                        state <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        cnt      <= '0;
                        done     <= 1'b1;
                        out_fe   <= !rx_line;
                        out_pe   <= perr;
                        out_byte <= fmt.bits8 ? data : {1'b0, data[6:0]};
                        state    <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_no_rx_without_carrier_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !$past(dcd_n));

    assert_seven_bit_msb_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(fmt.bits8)) |-> !out_byte[7]);

    assert_held_when_reset_R9: assert property (@(posedge clk) disable iff (rst)
        hold |=> (state == ST_IDLE) && !done);

    assert_no_parity_in_n_fmt_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(fmt.has_par)) |-> !out_pe);

endmodule

// File: rtl/rx_status.sv
module rx_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       mreset,
    input  logic       rd_clr,
    input  logic       done,
    input  logic [7:0] in_byte,
    input  logic       in_fe,
    input  logic       in_pe,
    output logic       rdrf,
    output logic       ovrn,
    output logic       fe,
    output logic       pe,
    output logic [7:0] buf_byte
);
    logic keep_old;

    assign keep_old = rdrf && !rd_clr;

    always_ff @(posedge clk) begin
        if (rst || mreset) begin
            rdrf     <= 1'b0;
            ovrn     <= 1'b0;
            fe       <= 1'b0;
            pe       <= 1'b0;
            buf_byte <= '0;
        end else begin
            if (rd_clr) begin
                rdrf <= 1'b0;
                ovrn <= 1'b0;
                fe   <= 1'b0;
                pe   <= 1'b0;
            end
            if (done) begin
                if (keep_old) begin
                    ovrn <= 1'b1;
                end else begin
                    rdrf     <= 1'b1;
                    ovrn     <= 1'b0;
                    fe       <= in_fe;
                    pe       <= in_pe;
                    buf_byte <= in_byte;
                end
            end
        end
    end

    assert_overrun_needs_full_R6: assert property (@(posedge clk) disable iff (rst)
        ovrn |-> rdrf);

    assert_byte_kept_while_full_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rdrf && !rd_clr && !mreset) |-> $stable(buf_byte));

    assert_full_falls_on_read_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rdrf) |-> $past(rd_clr || mreset));

endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
    import serial_rx_pkg::*;
#(
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_en,
    input  logic       sel,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       rx_line,
    input  logic       dcd_n,
    input  logic       cts_n,
    output logic       irq
);
    rx_ctrl_t   ctrl;
    fmt_info_t  fmt;
    logic       mreset, hold, rd_clr;
    logic       done, d_fe, d_pe;
    logic [7:0] d_byte, buf_byte;
    logic       rdrf, ovrn, fe, pe;
    logic [7:0] status;

    assign fmt    = decode_fmt(ctrl.fmt);
    assign rd_clr = rd_en && sel;

    rx_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_en && !sel),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .mreset  (mreset),
        .hold    (hold)
    );

    rx_deframer #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_deframer (
        .clk      (clk),
        .rst      (rst),
        .os_en    (os_en),
        .rx_line  (rx_line),
        .dcd_n    (dcd_n),
        .hold     (hold),
        .div      (ctrl.div),
        .fmt      (fmt),
        .done     (done),
        .out_byte (d_byte),
        .out_fe   (d_fe),
        .out_pe   (d_pe)
    );

    rx_status u_status (
        .clk      (clk),
        .rst      (rst),
        .mreset   (mreset),
        .rd_clr   (rd_clr),
        .done     (done),
        .in_byte  (d_byte),
        .in_fe    (d_fe),
        .in_pe    (d_pe),
        .rdrf     (rdrf),
        .ovrn     (ovrn),
        .fe       (fe),
        .pe       (pe),
        .buf_byte (buf_byte)
    );

    assign irq     = ctrl.rie && rdrf;
    assign status  = {irq, pe, ovrn, fe, cts_n, dcd_n, 1'b0, rdrf};
    assign rd_data = sel ? buf_byte : status;

    assert_full_needs_carrier_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rdrf) |-> !$past(dcd_n));

    assert_master_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $past(mreset) |-> (status[7:4] == 4'b0000) && !status[0]);

endmodule

// File: tb/serial_rx_port_tb.sv
module serial_rx_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DMID  = 16;
    localparam int DSLOW = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_en = 1'b1;
    logic       sel = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rx_line = 1'b1;
    logic       dcd_n = 1'b0;
    logic       cts_n = 1'b1;
    logic       irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;
    logic rie_now = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_port #(.DIV_MID(DMID), .DIV_SLOW(DSLOW)) dut_i (
        .clk(clk), .rst(rst), .os_en(os_en), .sel(sel), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rx_line(rx_line),
        .dcd_n(dcd_n), .cts_n(cts_n), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic full, input logic ov,
                                              input logic f, input logic p);
        return {rie_now & full, p, ov, f, cts_n, dcd_n, 1'b0, full};
    endfunction

    function automatic int ticks(input logic [1:0] d);
        return (d == 2'b01) ? DMID : (d == 2'b10) ? DSLOW : 1;
    endfunction

    task automatic write_ctrl(input logic [7:0] b);
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b1; wr_data = b;
        rie_now = (b[1:0] == 2'b11) ? rie_now : b[7];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic s, output logic [7:0] v);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0; sel = 1'b0;
    endtask

    task automatic send_bit(input logic b, input int d);
        rx_line = b;
        repeat (d) @(negedge clk);
    endtask

    task automatic send_frame(input logic [2:0] f, input logic [1:0] dv, input logic [7:0] b,
                              input logic bad_par, input logic bad_stop);
        int  d = ticks(dv);
        int  nb = f[2] ? 8 : 7;
        logic has_par = !(f == 3'b100 || f == 3'b101);
        logic odd = f[2] ? (f == 3'b111) : f[0];
        logic two = (f == 3'b000 || f == 3'b001 || f == 3'b100);
        logic x = 1'b0;
        @(negedge clk);
        send_bit(1'b0, d);
        for (int i = 0; i < nb; i++) begin
            send_bit(b[i], d);
            x ^= b[i];
        end
        if (has_par) send_bit(x ^ odd ^ bad_par, d);
        send_bit(!bad_stop, d);
        if (two) send_bit(1'b1, d);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 8'h1, 8'h0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, receiver held
        read_reg(1'b0, v);
        check("R1 reset status", v, 8'h08);
        send_frame(3'b101, 2'b00, 8'h5A, 1'b0, 1'b0);
        read_reg(1'b0, v);
        check("R9 held after reset", v, 8'h08);

        // R3/R2: basic 8N1 divide-by-16
        write_ctrl({1'b0, 2'b00, 3'b101, 2'b01});
        send_frame(3'b101, 2'b01, 8'hA5, 1'b0, 1'b0);
        read_reg(1'b0, v);
        check("R3 status after 8N1", v, exp_status(1, 0, 0, 0));
        read_reg(1'b1, v);
        check("R2 data 8N1", v, 8'hA5);
        read_reg(1'b0, v);
        check("R2 flags cleared by read", v, exp_status(0, 0, 0, 0));

        // R8: short low glitch rejected at mid-bit
        @(negedge clk); rx_line = 1'b0;
        repeat (4) @(negedge clk); rx_line = 1'b1;
        repeat (60) @(negedge clk);
        read_reg(1'b0, v);
        check("R8 false start ignored", v, exp_status(0, 0, 0, 0));

        // R6: overrun keeps first byte
        send_frame(3'b101, 2'b01, 8'h11, 1'b0, 1'b0);
        send_frame(3'b101, 2'b01, 8'h22, 1'b0, 1'b0);
        read_reg(1'b0, v);
        check("R6 overrun status", v, exp_status(1, 1, 0, 0));
        read_reg(1'b1, v);
        check("R6 first byte kept", v, 8'h11);
        read_reg(1'b0, v);
        check("R2 overrun cleared", v, exp_status(0, 0, 0, 0));

        // R7: carrier absent
        dcd_n = 1'b1;
        send_frame(3'b101, 2'b01, 8'h3C, 1'b0, 1'b0);
        read_reg(1'b0, v);
        check("R7 no rx without carrier", v, 8'h0C);
        dcd_n = 1'b0;
        read_reg(1'b0, v);
        check("R7 carrier bit follows", v, 8'h08);

        // R11: clear-to-send reflection
        cts_n = 1'b0;
        read_reg(1'b0, v);
        check("R11 cts active", v, 8'h00);
        cts_n = 1'b1;

        // R10: interrupt
        write_ctrl({1'b1, 2'b00, 3'b110, 2'b00});
        send_frame(3'b110, 2'b00, 8'hC3, 1'b0, 1'b0);
        check("R10 irq raised", {7'b0, irq}, 8'h01);
        read_reg(1'b0, v);
        check("R10 status irq bit", v, exp_status(1, 0, 0, 0));
        read_reg(1'b1, v);
        check("R10 data", v, 8'hC3);
        check("R10 irq cleared", {7'b0, irq}, 8'h00);

        // R9: master reset with full buffer
        send_frame(3'b110, 2'b00, 8'h0F, 1'b1, 1'b1);
        write_ctrl(8'h03);
        read_reg(1'b0, v);
        check("R9 master reset clears", v, 8'h08);
        send_frame(3'b110, 2'b00, 8'h0F, 1'b0, 1'b0);
        read_reg(1'b0, v);
        check("R9 held after master reset", v, 8'h08);

        // Random frames: R3 R4 R5 R8 across formats and divisors
        for (int k = 0; k < 40; k++) begin
            logic [2:0] f  = 3'($urandom % 8);
            logic [1:0] dv = 2'($urandom % 3);
            logic [7:0] b  = 8'($urandom);
            logic hp = !(f == 3'b100 || f == 3'b101);
            logic bp = hp && (($urandom % 5) == 0);
            logic bs = (($urandom % 6) == 0);
            logic [7:0] eb = f[2] ? b : {1'b0, b[6:0]};
            write_ctrl({1'(k % 2), 2'b00, f, dv});
            send_frame(f, dv, b, bp, bs);
            read_reg(1'b0, v);
            check("R3 R4 R5 random status", v, exp_status(1, 0, bs, bp));
            read_reg(1'b1, v);
            check("R3 random data", v, eb);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule